// File: doc/BRIEF.md
# Shared-DAC SAR Conversion Sequencer

This block is the digital control of an 8-bit successive-approximation converter that borrows the output DAC of the same chip. A control byte picks the analog output enable, one of four input arrangements, the auto-increment flag and a channel. The block turns the current channel into positive and negative multiplexer selects and a differential flag. Channel numbers that a mode does not have are replaced by its highest channel.

A one-cycle start request begins a conversion. The block holds the DAC output buffer and places trial codes on the shared DAC, most significant bit first. It reads an external comparator after each trial and stores the final code in a result register. It then gives the DAC back to the value software last wrote. Differential channels produce two's-complement results.

The result leaves on a plain strobe with no back-pressure. `result_done` pulses for one cycle and `result` keeps its value until the next conversion finishes, so a consumer may read it at any time. Start requests are not queued: a request made while a conversion runs is dropped.

Top module: `adc_chan_sar`

## Requirements
- R1: While reset is asserted and after it is released: `result` is 0x80, `busy`, `hold` and `result_done` are 0, the control register is all zero (mode 00, channel 0, no auto-increment, `aout_en` 0, `osc_en` 0), `dac_code` is 0.
- R2: `ctrl_wr` loads the control byte: bit 6 is output enable, bits 5:4 the input mode, bit 2 auto-increment, bits 1:0 the channel. Bits 7 and 3 have no effect on any output.
- R3: Mode 00: channel n routes input n to `mux_pos` with `diff_sel` 0. On every single-ended channel `mux_neg` is 0.
- R4: Mode 01: channel n (0..2) gives `mux_pos`=n, `mux_neg`=3, `diff_sel` 1.
- R5: Mode 10: channels 0 and 1 are single-ended inputs 0 and 1, and channel 2 is differential with pos 2 and neg 3.
- R6: Mode 11: channel 0 is differential with pos 0 and neg 1, and channel 1 is differential with pos 2 and neg 3.
- R7: A written channel above the mode's highest (3 in mode 00, 2 in modes 01/10, 1 in mode 11) is stored as that highest channel.
- R8: With auto-increment set, the channel advances by one on the same edge that stores a result. It goes to 0 after the highest channel. Without the flag it stays. A control write on that edge takes priority.
- R9: A start request sampled while idle raises `busy` and `hold` on that edge for exactly 8 cycles. On the edge that lowers them, `result` updates and `result_done` pulses for one cycle.
- R10: The first trial on `dac_code` is 0x80. On each following edge the bit under trial is kept if `cmp_ge` is 1 and cleared otherwise, and the next lower bit is set, down to bit 0.
- R11: Single-ended results are the final trial code. Differential results are that code with bit 7 inverted, so the most negative input gives 0x80 and the most positive gives 0x7F.
- R12: A start request sampled while `busy` is 1 has no effect on the running conversion or its timing.
- R13: While idle, `dac_code` shows the last value written with `dac_wr`. A write made during a conversion appears once the conversion ends.
- R14: `aout_en` equals control bit 6. `osc_en` is 1 when bit 6 is 1 or a conversion runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_wr | input | 1 | Load `ctrl_data` into the control register |
| ctrl_data | input | 8 | Control byte |
| dac_wr | input | 1 | Load `dac_data` into the DAC register |
| dac_data | input | DATA_W | Value for the analog output |
| conv_start | input | 1 | One-cycle conversion request |
| cmp_ge | input | 1 | Comparator: input at or above the trial level |
| mux_pos | output | 2 | Positive input select |
| mux_neg | output | 2 | Negative input select |
| diff_sel | output | 1 | Current channel is differential |
| chan_sel | output | 2 | Current channel number |
| dac_code | output | DATA_W | Code applied to the shared DAC |
| hold | output | 1 | Track/hold control of the output buffer |
| aout_en | output | 1 | Analog output buffer enable |
| osc_en | output | 1 | Oscillator enable |
| busy | output | 1 | Conversion in progress |
| result | output | DATA_W | Last conversion result |
| result_done | output | 1 | One-cycle strobe when `result` updates |

## Verification
The comparator is modelled as an ideal analog input placed in front of the design's own multiplexer selects. A wrong route therefore shows up as a wrong code, and the reference also checks the selects directly. Input levels of 0, 0xFF and mid-scale single-ended values test the keep/clear decision at both rails. Differential pairs at full positive, zero and full negative difference tell the inverted-MSB encoding apart from plain offset binary. Sweeps with auto-increment in each mode, out-of-range channel writes, repeated start requests mid-conversion and DAC writes during a conversion tell apart wrap, clamp, ignore and restore behaviour. A randomised run then mixes all of these.

// File: rtl/adcq_pkg.sv
package adcq_pkg;
  localparam int CH_W = 2;

  typedef enum logic [1:0] {
    MODE_SE4   = 2'b00,
    MODE_DIFF3 = 2'b01,
    MODE_MIX   = 2'b10,
    MODE_DIFF2 = 2'b11
  } in_mode_e;

  typedef struct packed {
    logic [CH_W-1:0] pos;
    logic [CH_W-1:0] neg;
    logic            diff;
  } route_t;

  // highest channel index a mode offers
  function automatic logic [CH_W-1:0] last_chan(in_mode_e m);
    case (m)
      MODE_SE4:             return 2'd3;
      MODE_DIFF3, MODE_MIX: return 2'd2;
      default:              return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/adcq_route.sv
module adcq_route
  import adcq_pkg::*;
(
  input  in_mode_e        mode,
  input  logic [CH_W-1:0] chan,
  output route_t          route
);
  always_comb begin
    route = '0;
    case (mode)
      MODE_SE4: route.pos = chan;
      MODE_DIFF3: begin
        route.pos  = chan;
        route.neg  = 2'd3;
        route.diff = 1'b1;
      end
      MODE_MIX: begin
        route.pos = chan;
        if (chan == 2'd2) begin
          route.neg  = 2'd3;
          route.diff = 1'b1;
        end
      end
      default: begin
        route.diff = 1'b1;
        if (chan == 2'd0) begin
          route.pos = 2'd0;
          route.neg = 2'd1;
        end else begin
          route.pos = 2'd2;
          route.neg = 2'd3;
        end
      end
    endcase
  end
endmodule

// File: rtl/adcq_chan_ptr.sv
module adcq_chan_ptr
  import adcq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CH_W-1:0] load_chan,
  input  in_mode_e        load_mode,
  input  in_mode_e        cur_mode,
  input  logic            step_up,
  output logic [CH_W-1:0] chan
);
  logic [CH_W-1:0] lim_load, lim_cur;

  assign lim_load = last_chan(load_mode);
  assign lim_cur  = last_chan(cur_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan <= '0;
    end else if (load) begin
      chan <= (load_chan > lim_load) ? lim_load : load_chan;
    end else if (step_up) begin
      chan <= (chan >= lim_cur) ? '0 : chan + 1'b1;
    end
  end

  // R7: the stored channel never exceeds what the mode offers
  p_chan_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chan <= last_chan(cur_mode));
endmodule

// File: rtl/adcq_sar.sv
module adcq_sar #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         cmp_ge,
  input  logic         diff,
  output logic         busy,
  output logic         finishing,
  output logic [W-1:0] trial,
  output logic [W-1:0] result,
  output logic         done
);
  localparam int          SW  = (W > 1) ? $clog2(W) : 1;
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  logic [SW-1:0] step;
  logic [W-1:0]  decided;

  assign finishing = busy && (step == '0);

  // resolve the bit under trial and arm the next lower one
  always_comb begin
    decided = trial;
    for (int i = 0; i < W; i++) begin
      if (i == int'(step))     decided[i] = cmp_ge;
      if (i + 1 == int'(step)) decided[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      step   <= '0;
      trial  <= '0;
      result <= MID;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        trial <= decided;
        if (step == '0) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= diff ? {~decided[W-1], decided[W-2:0]} : decided;
        end else begin
          step <= step - 1'b1;
        end
      end else if (start) begin
        busy  <= 1'b1;
        trial <= MID;
        step  <= SW'(W-1);
      end
    end
  end

  // R10 / R12: steps descend one per cycle; a new start cannot reload them
  p_step_descends_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy && step != '0 |=> busy && step == $past(step) - 1'b1);
  // R10: each conversion opens at mid-scale
  p_first_trial_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> trial == MID);
  // R9: the strobe follows the last busy cycle
  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  // R11: result only moves with the strobe
  p_result_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

// File: rtl/adc_chan_sar.sv
module adc_chan_sar
  import adcq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [7:0]        ctrl_data,
  input  logic              dac_wr,
  input  logic [DATA_W-1:0] dac_data,
  input  logic              conv_start,
  input  logic              cmp_ge,
  output logic [1:0]        mux_pos,
  output logic [1:0]        mux_neg,
  output logic              diff_sel,
  output logic [1:0]        chan_sel,
  output logic [DATA_W-1:0] dac_code,
  output logic              hold,
  output logic              aout_en,
  output logic              osc_en,
  output logic              busy,
  output logic [DATA_W-1:0] result,
  output logic              result_done
);
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  logic              out_on_q, autoinc_q;
  in_mode_e          mode_q;
  logic [DATA_W-1:0] dac_reg;
  logic [DATA_W-1:0] trial;
  logic              finishing;
  logic [CH_W-1:0]   chan;
  route_t            route;
  logic              unused_ctrl;

  assign unused_ctrl = ctrl_data[7] ^ ctrl_data[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_on_q  <= 1'b0;
      autoinc_q <= 1'b0;
      mode_q    <= MODE_SE4;
    end else if (ctrl_wr) begin
      out_on_q  <= ctrl_data[6];
      autoinc_q <= ctrl_data[2];
      mode_q    <= in_mode_e'(ctrl_data[5:4]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dac_reg <= '0;
    else if (dac_wr) dac_reg <= dac_data;
  end

  adcq_chan_ptr u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ctrl_wr),
    .load_chan (ctrl_data[1:0]),
    .load_mode (in_mode_e'(ctrl_data[5:4])),
    .cur_mode  (mode_q),
    .step_up   (finishing && autoinc_q),
    .chan      (chan)
  );

  adcq_route u_route (
    .mode  (mode_q),
    .chan  (chan),
    .route (route)
  );

  adcq_sar #(.W(DATA_W)) u_sar (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (conv_start),
    .cmp_ge    (cmp_ge),
    .diff      (route.diff),
    .busy      (busy),
    .finishing (finishing),
    .trial     (trial),
    .result    (result),
    .done      (result_done)
  );

  assign mux_pos  = route.pos;
  assign mux_neg  = route.neg;
  assign diff_sel = route.diff;
  assign chan_sel = chan;
  assign hold     = busy;
  assign dac_code = busy ? trial : dac_reg;
  assign aout_en  = out_on_q;
  assign osc_en   = out_on_q | busy;

  // R3: single-ended channels leave the negative select at input 0
  p_se_neg_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !diff_sel |-> mux_neg == 2'd0);
  // R6: a differential pair never uses one input twice
  p_diff_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    diff_sel |-> mux_neg != mux_pos);
  // R10: the DAC shows mid-scale when the hold begins
  p_hold_mid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> dac_code == MID);
endmodule

// File: tb/test_adc_chan_sar.sv
module test_adc_chan_sar;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [7:0] ctrl_data = 8'h00;
  logic       dac_wr = 1'b0;
  logic [7:0] dac_data = 8'h00;
  logic       conv_start = 1'b0;
  logic       cmp_ge;
  logic [1:0] mux_pos, mux_neg, chan_sel;
  logic       diff_sel, hold, aout_en, osc_en, busy, result_done;
  logic [7:0] dac_code, result;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;
  int ain [4];
  int vin_b;

  always #4 clk = ~clk;

  adc_chan_sar i_adc_chan_sar (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
    .dac_wr(dac_wr), .dac_data(dac_data), .conv_start(conv_start),
    .cmp_ge(cmp_ge), .mux_pos(mux_pos), .mux_neg(mux_neg),
    .diff_sel(diff_sel), .chan_sel(chan_sel), .dac_code(dac_code),
    .hold(hold), .aout_en(aout_en), .osc_en(osc_en), .busy(busy),
    .result(result), .result_done(result_done)
  );

  function automatic int clamp8(int x);
    return (x < 0) ? 0 : ((x > 255) ? 255 : x);
  endfunction

  // ideal analog front end, driven by the design's selects
  always_comb begin
    if (diff_sel) vin_b = clamp8(ain[mux_pos] - ain[mux_neg] + 128);
    else          vin_b = ain[mux_pos];
    cmp_ge = (vin_b >= int'(dac_code));
  end

  // ---------------- reference model ----------------
  function automatic int mlast(int m);
    return (m == 0) ? 3 : ((m == 3) ? 1 : 2);
  endfunction
  function automatic int mdiff(int m, int c);
    return (m == 1 || m == 3 || (m == 2 && c == 2)) ? 1 : 0;
  endfunction
  function automatic int mpos(int m, int c);
    return (m == 3) ? ((c == 0) ? 0 : 2) : c;
  endfunction
  function automatic int mneg(int m, int c);
    if (m == 3) return (c == 0) ? 1 : 3;
    return mdiff(m, c) ? 3 : 0;
  endfunction
  function automatic int mval(int m, int c);
    if (mdiff(m, c)) return clamp8(ain[mpos(m, c)] - ain[mneg(m, c)] + 128);
    return ain[mpos(m, c)];
  endfunction

  int m_oe, m_mode, m_ai, m_ch, m_dac, m_busy, m_trial, m_step, m_res, m_done;
  int mv, m_adv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_oe = 0; m_mode = 0; m_ai = 0; m_ch = 0; m_dac = 0;
      m_busy = 0; m_trial = 0; m_step = 0; m_res = 128; m_done = 0;
    end else begin
      m_adv = 0;
      m_done = 0;
      if (m_busy != 0) begin
        mv = mval(m_mode, m_ch);
        if (mv < m_trial) m_trial = m_trial - (1 << m_step);
        if (m_step > 0) begin
          m_step = m_step - 1;
          m_trial = m_trial + (1 << m_step);
        end else begin
          m_busy = 0;
          m_done = 1;
          m_res = mdiff(m_mode, m_ch) ? (m_trial ^ 128) : m_trial;
          m_adv = m_ai;
        end
      end else if (conv_start) begin
        m_busy = 1; m_trial = 128; m_step = 7;
      end
      if (m_adv != 0) m_ch = (m_ch >= mlast(m_mode)) ? 0 : m_ch + 1;
      if (ctrl_wr) begin
        m_oe = ctrl_data[6];
        m_mode = ctrl_data[5:4];
        m_ai = ctrl_data[2];
        m_ch = (int'(ctrl_data[1:0]) > mlast(m_mode)) ? mlast(m_mode) : int'(ctrl_data[1:0]);
      end
      if (dac_wr) m_dac = dac_data;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string mode_tag(int m);
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      chk("R9 busy", busy, m_busy);
      chk("R9 hold", hold, m_busy);
      chk("R9 done", result_done, m_done);
      chk(m_busy ? "R10 dac_code trial" : "R13 dac_code idle", dac_code, m_busy ? m_trial : m_dac);
      chk("R11 result", result, m_res);
      chk("R8 chan", chan_sel, m_ch);
      chk(mode_tag(m_mode), {mux_pos, mux_neg, diff_sel},
          {27'd0, 2'(mpos(m_mode, m_ch)), 2'(mneg(m_mode, m_ch)), 1'(mdiff(m_mode, m_ch))});
      chk("R14 aout_en", aout_en, m_oe);
      chk("R14 osc_en", osc_en, (m_oe != 0 || m_busy != 0) ? 1 : 0);
    end
  end

  task automatic wr_ctrl(logic [7:0] b);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_data = b;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask
  task automatic wr_dac(logic [7:0] b);
    @(negedge clk); dac_wr = 1'b1; dac_data = b;
    @(negedge clk); dac_wr = 1'b0;
  endtask
  task automatic convert();
    @(negedge clk); conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0;
    repeat (9) @(negedge clk);
  endtask
  task automatic convert_exp(string req, int exp);
    convert();
    chk(req, result, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!ended) begin
      ended = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    ain[0] = 8'h5A; ain[1] = 8'hC3; ain[2] = 0; ain[3] = 255;
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk("R1 result", result, 8'h80);
    chk("R1 busy", busy, 0);
    chk("R1 osc_en", osc_en, 0);
    chk("R1 dac_code", dac_code, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 chan", chan_sel, 0);
    chk("R1 aout_en", aout_en, 0);

    wr_dac(8'h33);
    chk("R13 dac idle", dac_code, 8'h33);
    wr_ctrl(8'h40);
    chk("R14 aout on", aout_en, 1);
    convert_exp("R11 single-ended 0x5A", 8'h5A);

    // R8: auto-increment sweep with wrap in mode 00
    wr_ctrl(8'h04);
    convert_exp("R8 ch0", 8'h5A);
    convert_exp("R8 ch1", 8'hC3);
    convert_exp("R10 ch2 zero", 8'h00);
    convert_exp("R10 ch3 full", 8'hFF);
    chk("R8 wrap", chan_sel, 0);
    convert_exp("R8 ch0 again", 8'h5A);

    // R7: clamp in mode 01, then most negative differential
    wr_ctrl(8'h17);
    chk("R7 clamp mode01", chan_sel, 2);
    convert_exp("R11 diff most negative", 8'h80);
    chk("R8 wrap mode01", chan_sel, 0);

    // R6 / R7 in mode 11
    wr_ctrl(8'h33);
    chk("R7 clamp mode11", chan_sel, 1);
    ain[0] = 200; ain[1] = 50;
    wr_ctrl(8'h30);
    convert_exp("R11 diff most positive", 8'h7F);
    ain[1] = 200;
    convert_exp("R11 diff zero", 8'h00);

    // R5: mixed mode, single-ended then differential
    ain[0] = 10; ain[1] = 20; ain[2] = 100; ain[3] = 40;
    wr_ctrl(8'h25);
    convert_exp("R5 ch1 se", 8'h14);
    convert_exp("R5 ch2 diff", 8'h3C);
    convert_exp("R5 ch0 se", 8'h0A);
    chk("R8 advance", chan_sel, 1);

    // R12: second start inside a conversion is dropped
    @(negedge clk); conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0;
    repeat (2) @(negedge clk);
    conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R12 still busy", busy, 1);
    @(negedge clk);
    chk("R12 ended on time", busy, 0);
    chk("R9 done strobe", result_done, 1);

    // R13: DAC write during conversion shows afterwards
    @(negedge clk); conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0; dac_wr = 1'b1; dac_data = 8'hA7;
    @(negedge clk); dac_wr = 1'b0;
    chk("R13 trial kept", busy, 1);
    repeat (8) @(negedge clk);
    chk("R13 restored", dac_code, 8'hA7);

    // R2: reserved bits have no effect
    wr_ctrl(8'h88);
    chk("R2 reserved aout", aout_en, 0);
    chk("R2 reserved chan", chan_sel, 0);
    chk("R2 reserved mode", diff_sel, 0);

    // mixed random run
    for (int k = 0; k < 40; k++) begin
      for (int j = 0; j < 4; j++) ain[j] = int'($urandom_range(0, 255));
      wr_ctrl(8'($urandom));
      if ($urandom_range(0, 1) == 1) wr_dac(8'($urandom));
      @(negedge clk); conv_start = 1'b1;
      @(negedge clk); conv_start = 1'b0;
      repeat (int'($urandom_range(0, 6))) @(negedge clk);
      conv_start = 1'(($urandom_range(0, 1)));
      @(negedge clk); conv_start = 1'b0;
      repeat (9) @(negedge clk);
    end

    ended = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule